// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus that carries four command/byte-enable lines alongside it. When the local agent drives the bus, the block registers the parity bit for the values on the wires. That bit appears one clock later, which is where the bus protocol expects the parity line to trail the data it covers.

When the local agent is the receiver, the block checks the parity line against the address/data and command/byte-enable values of the previous cycle. A bad ordinary data phase raises a data parity error output two clocks after that data phase. The error output comes with its own output enable, which stays on for one extra clock so the shared line can be driven back to its idle level before it is released. A bad address phase, or a bad data phase of a special (broadcast) cycle, does not touch the data error output. It produces a one-clock pulse on the system error output with the same timing instead.

The surrounding interface logic supplies the phase indicators and owns arbitration and transaction sequencing. All outputs here are active high; any inversion to active-low pins happens at the pad.

Top module: `pci_parity_unit`

## Requirements
- R1: If `drive_i` is high when sampled at edge n, then after edge n+1 `par_o` makes the number of ones in {`ad_i`, `cbe_i`, `par_o`} even, counting `ad_i` and `cbe_i` as sampled at edge n.
- R2: `par_oe_o` is high in the cycle after edge n exactly when `drive_i` was high at edge n.
- R3: A data check applies at edge n when `rcv_i`=1, `data_done_i`=1, `special_i`=0 and `addr_phase_i`=0. If the number of ones in {`ad_i`, `cbe_i` at edge n, `par_i` at edge n+1} is odd, `perr_o` is high for the one cycle that follows edge n+1.
- R4: A data check whose parity count is even leaves `perr_o` low in that cycle.
- R5: Consecutive bad data phases keep `perr_o` high for one consecutive cycle per bad phase, with no gap between them.
- R6: `perr_oe_o` is high in every cycle in which `perr_o` is high and in the single cycle after `perr_o` falls. It is low at all other times.
- R7: A phase with `rcv_i`=1, `data_done_i`=1, `special_i`=1 and `addr_phase_i`=0 whose parity count is odd pulses `serr_o` for the cycle after edge n+1 and never raises `perr_o`.
- R8: A phase with `rcv_i`=1 and `addr_phase_i`=1 whose parity count is odd pulses `serr_o` for the cycle after edge n+1. The address phase takes priority over `data_done_i` and `special_i` sampled in the same cycle.
- R9: Phases with `rcv_i`=0, or with both `addr_phase_i`=0 and `data_done_i`=0, never cause `perr_o` or `serr_o`, whatever their parity.
- R10: While `rst_n` is low, `par_o`, `par_oe_o`, `perr_o`, `perr_oe_o` and `serr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable line value |
| par_i | input | 1 | Parity line value, covering the previous cycle |
| drive_i | input | 1 | Local agent drives AD and C/BE this cycle |
| addr_phase_i | input | 1 | This cycle is an address phase |
| data_done_i | input | 1 | A data phase completes this cycle |
| special_i | input | 1 | Current transaction is a special cycle |
| rcv_i | input | 1 | Local agent is the receiver of this phase |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity line |
| perr_o | output | 1 | Data parity error report |
| perr_oe_o | output | 1 | Output enable for the data parity error line |
| serr_o | output | 1 | System error pulse for address or special-cycle parity errors |

## Verification
The hardest case to reach from the ports is a run of adjacent bad data phases mixed with a special-cycle or address error. In that case the error enable tail of one report overlaps the next report, and both error outputs have to stay mutually exclusive. The stimulus reaches it because each cycle's parity line is computed from the previous cycle's bus value with an independent corrupt bit. A full sweep of every phase-indicator combination against both good and bad parity runs as one unbroken stream, so every ordering of neighbouring phase kinds comes up. A long pseudo-random stream and an explicit burst of three bad data phases follow it.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // Kind of parity check pending for the cycle that carries PAR
    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_DATA = 2'd1,
        CK_SPEC = 2'd2,
        CK_ADDR = 2'd3
    } chk_kind_e;

    typedef struct packed {
        logic par;
        logic oe;
    } gen_st_t;

    typedef struct packed {
        chk_kind_e kind;
        logic      exp_par;
        logic      perr;
        logic      perr_oe;
        logic      serr;
    } chk_st_t;

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
    parameter int AD_W   = 32,
    parameter int CBE_W  = 4,
    parameter int LANE_W = 8
) (
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    output logic             sum_o
);
    localparam int LANES = AD_W / LANE_W;

    logic [LANES-1:0] lane_par;

    // One XOR reduction per byte lane, then a combine stage
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_par[g] = ^ad_i[g*LANE_W +: LANE_W];
    end

    assign sum_o = (^lane_par) ^ (^cbe_i);

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drive_i,
    input  logic sum_i,
    output logic par_o,
    output logic par_oe_o
);
    gen_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.oe  = drive_i;
        if (drive_i) begin
            st_d.par = sum_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_o    = st_q.par;
    assign par_oe_o = st_q.oe;

    AST_OE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i |=> par_oe_o); // R2
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_i |=> !par_oe_o); // R2
    AST_PAR_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i |=> (par_o == $past(sum_i))); // R1

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase_i,
    input  logic data_done_i,
    input  logic special_i,
    input  logic rcv_i,
    input  logic sum_i,
    input  logic par_i,
    output logic perr_o,
    output logic perr_oe_o,
    output logic serr_o
);
    chk_st_t st_d, st_q;
    logic    mismatch;

    always_comb begin
        st_d = st_q;

        // Classify this cycle; address phase wins over data indicators
        if (rcv_i && addr_phase_i) begin
            st_d.kind = CK_ADDR;
        end else if (rcv_i && data_done_i) begin
            st_d.kind = special_i ? CK_SPEC : CK_DATA;
        end else begin
            st_d.kind = CK_NONE;
        end
        st_d.exp_par = sum_i;

        // PAR for the phase registered last cycle is on the pin now
        mismatch     = (st_q.kind != CK_NONE) && (par_i != st_q.exp_par);
        st_d.perr    = mismatch && (st_q.kind == CK_DATA);
        st_d.serr    = mismatch && ((st_q.kind == CK_SPEC) || (st_q.kind == CK_ADDR));
        st_d.perr_oe = st_d.perr || st_q.perr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_o    = st_q.perr;
    assign perr_oe_o = st_q.perr_oe;
    assign serr_o    = st_q.serr;

    AST_PERR_HAS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> perr_oe_o); // R6
    AST_OE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_o) |-> perr_oe_o); // R6
    AST_OE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        perr_oe_o |-> (perr_o || $past(perr_o))); // R6
    AST_PERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(data_done_i && rcv_i && !special_i && !addr_phase_i, 2)); // R3
    AST_SERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(rcv_i && (addr_phase_i || (data_done_i && special_i)), 2)); // R8
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(perr_o && serr_o)); // R7

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
    parameter int AD_W   = 32,
    parameter int CBE_W  = 4,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             par_i,
    input  logic             drive_i,
    input  logic             addr_phase_i,
    input  logic             data_done_i,
    input  logic             special_i,
    input  logic             rcv_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_o,
    output logic             perr_oe_o,
    output logic             serr_o
);
    logic sum;

    // One shared reduction feeds both generation and checking
    pci_par_tree #(
        .AD_W   (AD_W),
        .CBE_W  (CBE_W),
        .LANE_W (LANE_W)
    ) u_tree (
        .ad_i  (ad_i),
        .cbe_i (cbe_i),
        .sum_o (sum)
    );

    pci_par_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_i  (drive_i),
        .sum_i    (sum),
        .par_o    (par_o),
        .par_oe_o (par_oe_o)
    );

    pci_par_chk u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_phase_i (addr_phase_i),
        .data_done_i  (data_done_i),
        .special_i    (special_i),
        .rcv_i        (rcv_i),
        .sum_i        (sum),
        .par_i        (par_i),
        .perr_o       (perr_o),
        .perr_oe_o    (perr_oe_o),
        .serr_o       (serr_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!perr_o && !serr_o) || rst_n); // R10

endmodule

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

    typedef struct packed {
        logic [31:0] ad;
        logic [3:0]  cbe;
        logic        par;
        logic        drive;
        logic        addr;
        logic        data;
        logic        spec;
        logic        rcv;
    } step_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        par_in, drive, addr_ph, data_done, special, rcv;
    logic        par_out, par_oe, perr, perr_oe, serr;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    step_t h1, h2, h3;
    logic [31:0] rng = 32'h1bad_5eed;

    always #2 clk = ~clk;

    pci_parity_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_i         (ad),
        .cbe_i        (cbe),
        .par_i        (par_in),
        .drive_i      (drive),
        .addr_phase_i (addr_ph),
        .data_done_i  (data_done),
        .special_i    (special),
        .rcv_i        (rcv),
        .par_o        (par_out),
        .par_oe_o     (par_oe),
        .perr_o       (perr),
        .perr_oe_o    (perr_oe),
        .serr_o       (serr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic bit is_data(input step_t s);
        return s.rcv && s.data && !s.addr && !s.spec;
    endfunction

    function automatic bit is_spec(input step_t s);
        return s.rcv && s.data && !s.addr && s.spec;
    endfunction

    function automatic bit is_addr(input step_t s);
        return s.rcv && s.addr;
    endfunction

    function automatic bit odd_count(input step_t ph, input step_t pr);
        return (($countones({ph.ad, ph.cbe}) + int'(pr.par)) % 2) == 1;
    endfunction

    // Check outputs for the history, then apply one new cycle of inputs
    task automatic apply(input logic [4:0] ctl, input logic [31:0] a, input logic [3:0] c,
                         input bit corrupt);
        step_t s;
        bit    ep, ep_prev, es;
        string tag;
        @(negedge clk);
        ep      = is_data(h2) && odd_count(h2, h1);
        ep_prev = is_data(h3) && odd_count(h3, h2);
        es      = (is_addr(h2) || is_spec(h2)) && odd_count(h2, h1);

        if (h1.drive)
            check("R1", "par_o even total", int'(par_out), $countones({h1.ad, h1.cbe}) % 2);
        check("R2", "par_oe_o", int'(par_oe), int'(h1.drive));

        if (ep)                tag = ep_prev ? "R5" : "R3";
        else if (is_data(h2))  tag = "R4";
        else if (is_spec(h2))  tag = "R7";
        else                   tag = "R9";
        check(tag, "perr_o", int'(perr), int'(ep));

        if (is_addr(h2))       tag = "R8";
        else if (is_spec(h2))  tag = "R7";
        else                   tag = "R9";
        check(tag, "serr_o", int'(serr), int'(es));

        check("R6", "perr_oe_o", int'(perr_oe), int'(ep || ep_prev));

        s.ad    = a;
        s.cbe   = c;
        s.par   = (($countones({h1.ad, h1.cbe}) % 2) == 1) ^ corrupt;
        s.drive = ctl[0];
        s.addr  = ctl[1];
        s.data  = ctl[2];
        s.spec  = ctl[3];
        s.rcv   = ctl[4];
        ad        = s.ad;
        cbe       = s.cbe;
        par_in    = s.par;
        drive     = s.drive;
        addr_ph   = s.addr;
        data_done = s.data;
        special   = s.spec;
        rcv       = s.rcv;
        h3 = h2;
        h2 = h1;
        h1 = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        h1 = '0; h2 = '0; h3 = '0;
        rst_n = 1'b0;
        ad = '0; cbe = '0; par_in = 1'b0;
        drive = 1'b0; addr_ph = 1'b0; data_done = 1'b0; special = 1'b0; rcv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset par_o", int'(par_out), 0);
        check("R10", "reset par_oe_o", int'(par_oe), 0);
        check("R10", "reset perr_o", int'(perr), 0);
        check("R10", "reset perr_oe_o", int'(perr_oe), 0);
        check("R10", "reset serr_o", int'(serr), 0);
        rst_n = 1'b1;

        // Full sweep of indicator combinations against good and bad parity
        for (int ctl = 0; ctl < 32; ctl++) begin
            for (int b = 0; b < 2; b++) begin
                for (int rep = 0; rep < 4; rep++) begin
                    rng = next_rng(rng);
                    apply(5'(ctl), rng, rng[7:4] ^ 4'(rep), b[0]);
                end
            end
        end

        // Directed burst: three bad data phases back to back, then a good one
        for (int k = 0; k < 3; k++) begin
            rng = next_rng(rng);
            apply(5'b10100, rng, 4'(k), k != 0);
        end
        apply(5'b10100, 32'hffff_0000, 4'hf, 1'b1);
        apply(5'b00000, 32'h0, 4'h0, 1'b0);
        apply(5'b00000, 32'h0, 4'h0, 1'b0);

        // Pseudo-random stream
        for (int k = 0; k < 4000; k++) begin
            rng = next_rng(rng);
            apply(rng[4:0], next_rng(rng), rng[11:8], rng[20] ^ rng[27]);
        end

        for (int k = 0; k < 3; k++) apply(5'b00000, 32'h0, 4'h0, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule